// File: doc/BRIEF.md
# Edge-Polarity GPIO Port

This block is a sixteen-pin general-purpose I/O port with a 16-bit register bus. Software sets the output value, chooses for each pin whether it is an input or a driven output, and picks for each input whether a rising or a falling transition is of interest. Transitions that pass the per-pin mask are latched in a sticky status register. The block's single interrupt request stays high while any status bit is set.

External pin levels pass through a two-flop synchronizer before they are used. An edge is detected by comparing the synchronized level with its value one clock earlier. The input-data register returns the synchronized levels gated by a separate pin-control register. The register bus is a plain synchronous strobe interface, not a stream. An access is taken in the cycle where `bus_sel` is high. Read data appears on `bus_rdata` in the following cycle and is zero in every other cycle. The bus has no back-pressure and accepts one access per cycle.

Top module: `edge_gpio_port`

## Requirements
- R1: After reset, the output, direction, polarity, mask and pin-control registers read 0xFFFF. The status register reads 0x0000, the input-data register reads 0x0000, `pin_oe` is 0 and `irq` is 0.
- R2: Register byte offsets are: 0x00 input data (read only), 0x04 output data, 0x08 direction, 0x0C edge polarity, 0x10 interrupt mask, 0x14 interrupt status, 0x18 pin control. A 16-bit write to a writable register is returned by a 16-bit read of the same offset, one cycle after that read.
- R3: Direction bit 1 means input and bit 0 means output. `pin_oe` equals the inverted direction register, and `pin_out` equals the output data ANDed with the inverted direction. Both follow any write of either register.
- R4: A 16-bit read of offset 0x00 returns the two-flop-synchronized pin levels ANDed with the pin-control register.
- R5: Polarity bit 1 selects a rising transition and polarity bit 0 selects a falling transition. A selected transition on `pin_in` sets the pin's status bit three clock edges after the pin changes.
- R6: A transition sets a status bit only if the pin's direction bit is 1 and its mask bit is 0.
- R7: Writing the status register clears each bit written as 1 and leaves the other bits unchanged. `irq` is high exactly while some status bit is set, and it falls only after a status write.
- R8: If a newly detected edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R9: `bus_size` encodes 0 as byte, 1 as 16-bit and 2 or 3 as 32-bit. An access whose size is not 16-bit changes no state, and such a read returns zero.
- R10: A write to offset 0x00 or to an unmapped offset changes no state. A read of an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_size | input | 2 | Access width code: 0 byte, 1 16-bit, 2 or 3 32-bit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle after a read |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Driven pin values |
| pin_oe | output | 16 | Per-pin drive enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: sixteen pins, an 8-bit offset and a two-stage synchronizer. This width makes every bit of the polarity, mask and direction registers reachable through random 16-bit patterns, and lets all seven mapped offsets and the unmapped ones next to them be hit by random addressing. The two-stage depth fixes the three-edge delay from a pin change to the status bit, and the bench uses that delay to line up a clearing write with a fresh edge on the same bit.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int OFFS_W = 8;

  localparam logic [OFFS_W-1:0] OFFS_INPUT  = 8'h00;
  localparam logic [OFFS_W-1:0] OFFS_OUTPUT = 8'h04;
  localparam logic [OFFS_W-1:0] OFFS_DIR    = 8'h08;
  localparam logic [OFFS_W-1:0] OFFS_POL    = 8'h0C;
  localparam logic [OFFS_W-1:0] OFFS_MASK   = 8'h10;
  localparam logic [OFFS_W-1:0] OFFS_STAT   = 8'h14;
  localparam logic [OFFS_W-1:0] OFFS_PCTL   = 8'h18;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_HALF  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_WORD2 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_port_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_size,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  in_sync,
  input  logic [W-1:0]  status,
  output logic [W-1:0]  out_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  pol_q,
  output logic [W-1:0]  mask_q,
  output logic [W-1:0]  clr_vec
);
  logic [W-1:0] pctl_q;
  logic         acc_ok, wen, ren;
  logic [W-1:0] rd_mux;

  assign acc_ok = bus_sel && (acc_size_e'(bus_size) == ACC_HALF);
  assign wen    = acc_ok && bus_wr;
  assign ren    = acc_ok && !bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '1;
      dir_q  <= '1;
      pol_q  <= '1;
      mask_q <= '1;
      pctl_q <= '1;
    end else if (wen) begin
      case (bus_addr)
        AW'(OFFS_OUTPUT): out_q  <= bus_wdata;
        AW'(OFFS_DIR):    dir_q  <= bus_wdata;
        AW'(OFFS_POL):    pol_q  <= bus_wdata;
        AW'(OFFS_MASK):   mask_q <= bus_wdata;
        AW'(OFFS_PCTL):   pctl_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign clr_vec = (wen && bus_addr == AW'(OFFS_STAT)) ? bus_wdata : '0;

  always_comb begin
    case (bus_addr)
      AW'(OFFS_INPUT):  rd_mux = in_sync & pctl_q;
      AW'(OFFS_OUTPUT): rd_mux = out_q;
      AW'(OFFS_DIR):    rd_mux = dir_q;
      AW'(OFFS_POL):    rd_mux = pol_q;
      AW'(OFFS_MASK):   rd_mux = mask_q;
      AW'(OFFS_STAT):   rd_mux = status;
      AW'(OFFS_PCTL):   rd_mux = pctl_q;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   bus_rdata <= '0;
    else if (ren) bus_rdata <= rd_mux;
    else          bus_rdata <= '0;
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_sync,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] pol_q,
  input  logic [W-1:0] mask_q,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] status,
  output logic         irq
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= in_sync;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic rise, fall;
      assign rise   = in_sync[i] & ~prev_q[i];
      assign fall   = ~in_sync[i] & prev_q[i];
      assign hit[i] = (pol_q[i] ? rise : fall) & dir_q[i] & ~mask_q[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_vec) | hit;
  end

  assign irq = |status;
endmodule

// File: rtl/edge_gpio_port.sv
module edge_gpio_port #(
  parameter int PIN_W       = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [PIN_W-1:0]  bus_wdata,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  output logic              irq
);
  logic [PIN_W-1:0] in_sync;
  logic [PIN_W-1:0] out_q, dir_q, pol_q, mask_q;
  logic [PIN_W-1:0] clr_vec, status;

  gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (in_sync)
  );

  gpio_regbank #(.W(PIN_W), .AW(ADDR_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .in_sync   (in_sync),
    .status    (status),
    .out_q     (out_q),
    .dir_q     (dir_q),
    .pol_q     (pol_q),
    .mask_q    (mask_q),
    .clr_vec   (clr_vec)
  );

  gpio_edge_irq #(.W(PIN_W)) edge_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_sync (in_sync),
    .dir_q   (dir_q),
    .pol_q   (pol_q),
    .mask_q  (mask_q),
    .clr_vec (clr_vec),
    .status  (status),
    .irq     (irq)
  );

  assign pin_oe  = ~dir_q;
  assign pin_out = out_q & ~dir_q;
endmodule

// File: rtl/edge_gpio_port_chk.sv
module edge_gpio_port_chk #(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic [W-1:0]  bus_rdata,
  input logic [W-1:0]  pin_out,
  input logic [W-1:0]  pin_oe,
  input logic          irq,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  mask_q
);
  logic bad_size, stat_wr;
  assign bad_size = bus_sel && (bus_size != 2'd1);
  assign stat_wr  = bus_sel && bus_wr && (bus_size == 2'd1) && (bus_addr == AW'(8'h14));

  // R3
  drive_only_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  // R9
  bad_size_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_size && !bus_wr) |=> bus_rdata == '0);

  // R9
  bad_size_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_size && bus_wr) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R10
  input_reg_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == '0) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R7
  irq_falls_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(stat_wr));

  // R6
  irq_needs_open_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((dir_q & ~mask_q) != '0));
endmodule

bind edge_gpio_port edge_gpio_port_chk #(.W(PIN_W), .AW(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .dir_q     (dir_q),
  .mask_q    (mask_q)
);

// File: tb/edge_gpio_port_tb.sv
module edge_gpio_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd1;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [15:0] m_out = '1, m_dir = '1, m_pol = '1, m_mask = '1, m_ctl = '1;
  logic [15:0] m_stat = '0, m_in = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_gpio_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] hits(input logic [15:0] old_v, input logic [15:0] new_v);
    return ((m_pol & new_v & ~old_v) | (~m_pol & ~new_v & old_v)) & m_dir & ~m_mask;
  endfunction

  function automatic logic [15:0] model_read(input logic [7:0] a, input logic [1:0] sz);
    if (sz != 2'd1) return '0;
    case (a)
      8'h00: return m_in & m_ctl;
      8'h04: return m_out;
      8'h08: return m_dir;
      8'h0C: return m_pol;
      8'h10: return m_mask;
      8'h14: return m_stat;
      8'h18: return m_ctl;
      default: return '0;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sz);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if (sz == 2'd1) begin
      case (a)
        8'h04: m_out = d;
        8'h08: m_dir = d;
        8'h0C: m_pol = d;
        8'h10: m_mask = d;
        8'h14: m_stat = m_stat & ~d;
        8'h18: m_ctl = d;
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] sz, output logic [15:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_size = sz;
    @(negedge clk);
    bus_sel = 0;
    v = bus_rdata;
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
    m_stat = m_stat | hits(m_in, v);
    m_in = v;
  endtask

  task automatic check_pins(input string tag);
    chk({tag, " oe"}, pin_oe, ~m_dir);
    chk({tag, " out"}, pin_out, m_out & ~m_dir);
    chk({tag, " irq"}, {15'd0, irq}, {15'd0, (m_stat != 0)});
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset values
    for (int i = 0; i < 7; i++) begin
      rd(8'(i * 4), 2'd1, v);
      chk("R1 reset reg", v, model_read(8'(i * 4), 2'd1));
    end
    chk("R1 oe", pin_oe, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);

    // R2: round trip of writable registers
    wr(8'h0C, 16'h5A5A, 2'd1); rd(8'h0C, 2'd1, v); chk("R2 pol", v, 16'h5A5A);
    wr(8'h18, 16'hC3C3, 2'd1); rd(8'h18, 2'd1, v); chk("R2 pinctl", v, 16'hC3C3);

    // R5: rising on low byte, falling on high byte
    wr(8'h10, 16'h0000, 2'd1);
    wr(8'h0C, 16'h00FF, 2'd1);
    set_pins(16'hFFFF);
    rd(8'h14, 2'd1, v); chk("R5 rising", v, 16'h00FF);
    set_pins(16'h0000);
    rd(8'h14, 2'd1, v); chk("R5 falling", v, 16'hFFFF);
    chk("R7 irq high", {15'd0, irq}, 16'd1);

    // R7: write-one-to-clear
    wr(8'h14, 16'h0F0F, 2'd1);
    rd(8'h14, 2'd1, v); chk("R7 partial clear", v, 16'hF0F0);
    wr(8'h14, 16'hFFFF, 2'd1);
    rd(8'h14, 2'd1, v); chk("R7 full clear", v, 16'h0000);
    chk("R7 irq low", {15'd0, irq}, 16'd0);

    // R6: outputs and masked pins do not flag
    wr(8'h0C, 16'hFFFF, 2'd1);
    wr(8'h08, 16'hF0FF, 2'd1);
    wr(8'h10, 16'h000F, 2'd1);
    set_pins(16'hFFFF);
    rd(8'h14, 2'd1, v); chk("R6 qualified", v, 16'hF0F0);
    wr(8'h14, 16'hFFFF, 2'd1);

    // R3: pin drive
    wr(8'h04, 16'hA5C3, 2'd1);
    wr(8'h08, 16'h0F0F, 2'd1);
    chk("R3 oe", pin_oe, 16'hF0F0);
    chk("R3 out", pin_out, 16'hA0C0);

    // R4: input read gated by pin control
    wr(8'h18, 16'h3C3C, 2'd1);
    set_pins(16'h1234);
    rd(8'h00, 2'd1, v); chk("R4 input", v, 16'h1034);

    // R9: wrong-size accesses
    wr(8'h04, 16'h0000, 2'd0);
    wr(8'h08, 16'hFFFF, 2'd2);
    check_pins("R9 write ignored");
    rd(8'h04, 2'd2, v); chk("R9 word read", v, 16'h0000);
    rd(8'h04, 2'd0, v); chk("R9 byte read", v, 16'h0000);

    // R10: input register and unmapped offsets
    wr(8'h00, 16'h0000, 2'd1);
    wr(8'h20, 16'h0000, 2'd1);
    check_pins("R10 write ignored");
    rd(8'h04, 2'd1, v); chk("R10 out kept", v, 16'hA5C3);
    rd(8'h20, 2'd1, v); chk("R10 unmapped read", v, 16'h0000);

    // R8: edge and clear on the same bit in the same cycle
    wr(8'h08, 16'hFFFF, 2'd1);
    wr(8'h10, 16'h0000, 2'd1);
    wr(8'h0C, 16'hFFFF, 2'd1);
    set_pins(16'h0000);
    wr(8'h14, 16'hFFFF, 2'd1);
    set_pins(16'h0003);
    set_pins(16'h0000);
    rd(8'h14, 2'd1, v); chk("R8 setup", v, 16'h0003);
    @(negedge clk); pin_in = 16'h0001;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h14; bus_size = 2'd1; bus_wdata = 16'h0003;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    m_in = 16'h0001; m_stat = 16'h0001;
    rd(8'h14, 2'd1, v); chk("R8 edge wins", v, 16'h0001);
    wr(8'h14, 16'hFFFF, 2'd1);

    // Random phase (R2, R3, R5, R6, R7, R9, R10)
    for (int it = 0; it < 400; it++) begin
      logic [7:0]  a;
      logic [1:0]  sz;
      logic [15:0] d;
      a  = 8'(($urandom % 10) * 4);
      sz = 2'($urandom % 4);
      if (sz == 2'd3) sz = 2'd1;
      d  = 16'($urandom);
      if ($urandom % 2) wr(a, d, sz);
      else begin
        rd(a, sz, v);
        chk("R2 random read", v, model_read(a, sz));
      end
      set_pins(16'($urandom));
      rd(8'h14, 2'd1, v);
      chk("R5 random status", v, m_stat);
      check_pins("R3 random");
    end

    summary();
  end
endmodule